// File: doc/BRIEF.md
# Two-Lane Receive Deskew Aligner

This block sits behind a receiver that delivers one 160-bit parallel word per clock from two lanes on a single shared clock. Each lane carries a periodic alignment marker in a fixed bit of its word. Traffic can pass through the two lanes with different delays, so after reset their markers can reach this block in different cycles. The aligner finds the first marker on each lane and measures how far apart the two markers are. It then delays the earlier lane by that distance, so both lanes leave the block in step, and it raises an aligned flag.

Two word formats are supported, and a static mode input selects between them. In single-width format each lane word is one 80-bit unit. In double-width format each lane word holds two 40-bit halves, and the upper half follows the lower half in time. A marker in the upper half therefore arrives half a word later than a marker in the lower half. To correct skews that are not whole words, the aligner can shift a lane by half a word, which moves halves across cycle boundaries. Searching starts only while the receiver reports valid data. A skew wider than the supported range is reported on a sticky error flag.

The data path is a stream with no back-pressure: the upstream receiver cannot be stalled, so one word is taken on every clock and one word is delivered on every clock. The aligned flag is the only qualifier on the output, and the sink must accept every word. The mode input must be held steady while the receiver-ready input is high.

Top module: `lane_pair_deskew`

## Requirements
- R1: Lane 0 occupies input bits [79:0] and lane 1 occupies bits [159:80]. The output word uses the same layout.
- R2: In single-width mode (`dbl_width_i` = 0) the marker is bit 33 of each lane. Bit 73 of a lane is plain data in this mode and never starts or completes a search.
- R3: In double-width mode (`dbl_width_i` = 1) a lane's marker is bit 33 (lower half, half-slot 0) or bit 73 (upper half, half-slot 1, which is half a word later). All four lane combinations are handled. If both bits are set in one word, bit 33 is taken.
- R4: Skew is the distance, counted in half-words, from the first marker of the earlier lane to the first marker of the later lane. The earlier lane is delayed by exactly that distance and the later lane is not delayed, so both markers come out in the same output word at the same bit.
- R5: Correctable skew is at most 2 words in single-width mode and at most 1 word (2 half-words) in double-width mode.
- R6: A skew above the limit, or a later-lane marker that has not arrived once the limit is certain to be exceeded, sets `skew_err_o`. The flag stays set until reset, and `aligned_o` stays low meanwhile.
- R7: The later lane reaches the output 2 clocks after it is presented. The earlier lane reaches it 2 clocks plus its skew after it is presented.
- R8: `aligned_o` rises 2 clocks after the input word that holds the later marker is presented, together with the output word that holds both markers. It then stays high, and the output keeps the same delays.
- R9: Words presented while `rx_ready_i` is low are ignored by the search. A low `rx_ready_i` drops `aligned_o` 2 clocks later and restarts the search, except after an error.
- R10: While `aligned_o` is low, `data_o` is all zeros.
- R11: After reset `aligned_o`, `skew_err_o` and `data_o` are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Shared clock of both lanes |
| rst_n | input | 1 | Active-low synchronous reset |
| rx_ready_i | input | 1 | Receiver reports valid data |
| dbl_width_i | input | 1 | 1 = double-width words, 0 = single-width |
| rx_data_i | input | 160 | Received word, lane 1 in the upper 80 bits |
| data_o | output | 160 | Aligned word, same layout |
| aligned_o | output | 1 | Lanes aligned, data_o qualified |
| skew_err_o | output | 1 | Sticky: skew outside correctable range |

## Verification
The hardest case to reach is the double-width boundary. Here the later lane's marker arrives one cycle after the earlier one, and the half-slot of each marker alone decides whether the block locks at a skew of 1 or 2 halves, or fails at 3 halves. The same case has a timeout variant, where the earlier marker sits in the upper half and no partner arrives in the next word. The stimulus places markers in chosen cycles and halves for each lane, with a fresh reset before every case. A reference model, working from absolute half-word timestamps, predicts the flags and the re-packed data on every clock. Dropping receiver-ready in the middle of a search, and again after lock, covers the restart path.

// File: rtl/dskw_pkg.sv
package dskw_pkg;
  typedef enum logic [1:0] {
    ST_SEEK  = 2'd0,
    ST_WAIT  = 2'd1,
    ST_LOCK  = 2'd2,
    ST_FAULT = 2'd3
  } dskw_st_e;
endpackage

// File: rtl/dskw_lane_hist.sv
// Per-lane word history with a half-word granular delay tap.
module dskw_lane_hist #(
  parameter int LANE_W = 80,
  parameter int DEPTH  = 3,
  parameter int DW     = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [LANE_W-1:0] lane_i,
  input  logic [DW-1:0]     dly_i,
  output logic [LANE_W-1:0] newest_o,
  output logic [LANE_W-1:0] word_o
);
  localparam int HALF_W = LANE_W / 2;
  localparam int NHALF  = 2 * DEPTH;

  logic [LANE_W-1:0] hist_q [DEPTH];
  logic [HALF_W-1:0] half_s [NHALF];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < DEPTH; i++) hist_q[i] <= '0;
    end else begin
      hist_q[0] <= lane_i;
      for (int i = 1; i < DEPTH; i++) hist_q[i] <= hist_q[i-1];
    end
  end

  // newest-first half stream: upper half of a word is later than its lower half
  for (genvar g = 0; g < DEPTH; g++) begin : g_halves
    assign half_s[2*g]   = hist_q[g][LANE_W-1:HALF_W];
    assign half_s[2*g+1] = hist_q[g][HALF_W-1:0];
  end

  always_comb begin
    word_o = '0;
    for (int k = 0; k < NHALF - 1; k++) begin
      if (dly_i == DW'(k)) word_o = {half_s[k], half_s[k+1]};
    end
  end

  assign newest_o = hist_q[0];
endmodule

// File: rtl/dskw_mark_find.sv
// Locates the alignment marker of one lane word and reports its half-slot.
module dskw_mark_find #(
  parameter int LANE_W   = 80,
  parameter int MARK_BIT = 33
) (
  input  logic [LANE_W-1:0] word_i,
  input  logic              dbl_i,
  output logic              found_o,
  output logic              half_o
);
  localparam int HALF_W = LANE_W / 2;

  logic lo_hit, hi_hit;

  assign lo_hit  = word_i[MARK_BIT];
  assign hi_hit  = dbl_i & word_i[HALF_W + MARK_BIT];
  assign found_o = lo_hit | hi_hit;
  assign half_o  = hi_hit & ~lo_hit;
endmodule

// File: rtl/dskw_skew_ctrl.sv
// Marker search, skew measurement and lock/fault control.
module dskw_skew_ctrl
  import dskw_pkg::*;
#(
  parameter int MAX_SGL = 2,
  parameter int MAX_DBL = 1,
  parameter int DW      = 4
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                rdy_i,
  input  logic                dbl_i,
  input  logic [1:0]          found_i,
  input  logic [1:0]          half_i,
  output logic                lock_nxt_o,
  output logic                err_o,
  output logic [1:0][DW-1:0]  dly_nxt_o
);
  dskw_st_e          st_q, st_d;
  logic              lead_q, lead_d;
  logic              lead_half_q, lead_half_d;
  logic [DW-1:0]     wait_q, wait_d;
  logic [1:0][DW-1:0] dly_q, dly_d;

  logic              lag;
  logic [DW-1:0]     lim, kk, two_kk, gap, floor_nxt;

  assign lim       = dbl_i ? DW'(2 * MAX_DBL) : DW'(2 * MAX_SGL);
  assign lag       = ~lead_q;
  assign kk        = wait_q + DW'(1);
  assign two_kk    = {kk[DW-2:0], 1'b0};
  assign gap       = two_kk + DW'(half_i[lag]) - DW'(lead_half_q);
  assign floor_nxt = two_kk + DW'(2) - DW'(lead_half_q);

  always_comb begin
    st_d        = st_q;
    lead_d      = lead_q;
    lead_half_d = lead_half_q;
    wait_d      = wait_q;
    dly_d       = dly_q;
    if (st_q != ST_FAULT && !rdy_i) begin
      st_d  = ST_SEEK;
      dly_d = '0;
    end else begin
      case (st_q)
        ST_SEEK: begin
          if (found_i == 2'b11) begin
            st_d  = ST_LOCK;
            dly_d = '0;
            if (half_i[0] != half_i[1]) begin
              if (half_i[1]) dly_d[0] = DW'(1);
              else           dly_d[1] = DW'(1);
            end
          end else if (found_i != 2'b00) begin
            st_d        = ST_WAIT;
            lead_d      = found_i[1];
            lead_half_d = found_i[1] ? half_i[1] : half_i[0];
            wait_d      = '0;
          end
        end
        ST_WAIT: begin
          if (found_i[lag]) begin
            if (gap <= lim) begin
              st_d         = ST_LOCK;
              dly_d        = '0;
              dly_d[lead_q] = gap;
            end else begin
              st_d = ST_FAULT;
            end
          end else if (floor_nxt > lim) begin
            st_d = ST_FAULT;
          end else begin
            wait_d = kk;
          end
        end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st_q        <= ST_SEEK;
      lead_q      <= 1'b0;
      lead_half_q <= 1'b0;
      wait_q      <= '0;
      dly_q       <= '0;
    end else begin
      st_q        <= st_d;
      lead_q      <= lead_d;
      lead_half_q <= lead_half_d;
      wait_q      <= wait_d;
      dly_q       <= dly_d;
    end
  end

  assign lock_nxt_o = (st_d == ST_LOCK);
  assign err_o      = (st_q == ST_FAULT);
  assign dly_nxt_o  = dly_d;

  p_err_sticky_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == ST_FAULT) |=> (st_q == ST_FAULT));

  p_one_side_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == ST_LOCK) |-> (dly_q[0] == '0 || dly_q[1] == '0));

  p_bound_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == ST_LOCK) |-> (dly_q[0] <= lim && dly_q[1] <= lim));

  p_hold_lock_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == ST_LOCK && rdy_i) |=> (st_q == ST_LOCK && $stable(dly_q)));
endmodule

// File: rtl/lane_pair_deskew.sv
module lane_pair_deskew #(
  parameter int LANE_W       = 80,
  parameter int MARK_BIT     = 33,
  parameter int MAX_SKEW_SGL = 2,
  parameter int MAX_SKEW_DBL = 1
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                rx_ready_i,
  input  logic                dbl_width_i,
  input  logic [2*LANE_W-1:0] rx_data_i,
  output logic [2*LANE_W-1:0] data_o,
  output logic                aligned_o,
  output logic                skew_err_o
);
  localparam int DEPTH = MAX_SKEW_SGL + 1;
  localparam int DW    = $clog2(2 * MAX_SKEW_SGL + 4) + 1;

  logic                 rdy_q;
  logic                 aligned_q;
  logic [2*LANE_W-1:0]  data_q;
  logic [1:0]           found, half;
  logic [1:0][DW-1:0]   dly_nxt;
  logic                 lock_nxt;
  logic [LANE_W-1:0]    newest [2];
  logic [LANE_W-1:0]    picked [2];

  for (genvar ln = 0; ln < 2; ln++) begin : g_lane
    dskw_lane_hist #(.LANE_W(LANE_W), .DEPTH(DEPTH), .DW(DW)) u_hist (
      .clk      (clk),
      .rst_n    (rst_n),
      .lane_i   (rx_data_i[ln*LANE_W +: LANE_W]),
      .dly_i    (dly_nxt[ln]),
      .newest_o (newest[ln]),
      .word_o   (picked[ln])
    );
    dskw_mark_find #(.LANE_W(LANE_W), .MARK_BIT(MARK_BIT)) u_mark (
      .word_i  (newest[ln]),
      .dbl_i   (dbl_width_i),
      .found_o (found[ln]),
      .half_o  (half[ln])
    );
  end

  dskw_skew_ctrl #(.MAX_SGL(MAX_SKEW_SGL), .MAX_DBL(MAX_SKEW_DBL), .DW(DW)) u_ctrl (
    .clk        (clk),
    .rst_n      (rst_n),
    .rdy_i      (rdy_q),
    .dbl_i      (dbl_width_i),
    .found_i    (found),
    .half_i     (half),
    .lock_nxt_o (lock_nxt),
    .err_o      (skew_err_o),
    .dly_nxt_o  (dly_nxt)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rdy_q     <= 1'b0;
      aligned_q <= 1'b0;
      data_q    <= '0;
    end else begin
      rdy_q     <= rx_ready_i;
      aligned_q <= lock_nxt;
      data_q    <= lock_nxt ? {picked[1], picked[0]} : '0;
    end
  end

  assign aligned_o = aligned_q;
  assign data_o    = data_q;

  p_quiet_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !aligned_q |-> (data_q == '0));

  p_rdy_gate_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !rdy_q |=> !aligned_q);

  p_err_no_align_r6: assert property (@(posedge clk) disable iff (!rst_n)
    skew_err_o |-> !aligned_q);
endmodule

// File: tb/lane_pair_deskew_tb.sv
module lane_pair_deskew_tb;
  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         rdy = 1'b0;
  logic         dbl = 1'b0;
  logic [159:0] din = '0;
  logic [159:0] dout;
  logic         aligned, err;

  int n_chk = 0, n_fail = 0;
  bit done = 0;
  string tag = "R11";

  // reference model state
  logic [159:0] mq[$];
  bit           rq[$];
  int mst, lead, lead_t, edge_no;
  int mdly[2];

  always #2 clk = ~clk;

  lane_pair_deskew u_dut (
    .clk(clk), .rst_n(rst_n), .rx_ready_i(rdy), .dbl_width_i(dbl),
    .rx_data_i(din), .data_o(dout), .aligned_o(aligned), .skew_err_o(err)
  );

  task automatic chk(string req, logic [159:0] act, logic [159:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  function automatic logic [159:0] mkword(int f0, int f1);
    logic [159:0] w;
    for (int i = 0; i < 5; i++) w[i*32 +: 32] = $urandom;
    w[33]  = f0[0]; w[73]  = f0[1];
    w[113] = f1[0]; w[153] = f1[1];
    return w;
  endfunction

  function automatic logic [39:0] half_at(int l, int k);
    logic [79:0] w;
    w = mq[1 + k/2][l*80 +: 80];
    return (k % 2 == 0) ? w[79:40] : w[39:0];
  endfunction

  task automatic model_reset();
    mq.delete(); rq.delete();
    for (int i = 0; i < 4; i++) begin mq.push_back('0); rq.push_back(1'b0); end
    mst = 0; lead = 0; lead_t = 0; edge_no = 0; mdly[0] = 0; mdly[1] = 0;
  endtask

  // evaluate the word captured one edge earlier, then compare outputs
  task automatic model_edge(logic [159:0] w_in, bit r_in);
    logic [159:0] w, expd;
    bit r;
    int mk[2], hs[2], lim, diff, jj;
    mq.push_front(w_in); void'(mq.pop_back());
    rq.push_front(r_in); void'(rq.pop_back());
    edge_no++;
    w = mq[1]; r = rq[1]; jj = edge_no - 1;
    lim = dbl ? 2 : 4;
    for (int l = 0; l < 2; l++) begin
      mk[l] = 0; hs[l] = 0;
      if (w[l*80 + 33]) mk[l] = 1;
      else if (dbl && w[l*80 + 73]) begin mk[l] = 1; hs[l] = 1; end
    end
    if (mst != 3 && !r) begin
      mst = 0; mdly[0] = 0; mdly[1] = 0;
    end else if (mst == 0) begin
      if (mk[0] && mk[1]) begin
        mst = 2; mdly[0] = 0; mdly[1] = 0;
        if (hs[0] < hs[1]) mdly[0] = hs[1] - hs[0];
        if (hs[1] < hs[0]) mdly[1] = hs[0] - hs[1];
      end else if (mk[0] || mk[1]) begin
        mst = 1; lead = mk[1] ? 1 : 0; lead_t = 2*jj + hs[lead];
      end
    end else if (mst == 1) begin
      if (mk[1-lead]) begin
        diff = 2*jj + hs[1-lead] - lead_t;
        if (diff <= lim) begin
          mst = 2; mdly[0] = 0; mdly[1] = 0; mdly[lead] = diff;
        end else mst = 3;
      end else if (2*(jj+1) - lead_t > lim) mst = 3;
    end
    expd = '0;
    if (mst == 2)
      for (int l = 0; l < 2; l++)
        expd[l*80 +: 80] = {half_at(l, mdly[l]), half_at(l, mdly[l] + 1)};
    chk(tag, {159'd0, aligned}, {159'd0, (mst == 2)});
    chk((mst == 3) ? "R6" : tag, {159'd0, err}, {159'd0, (mst == 3)});
    chk((mst == 2) ? tag : "R10", dout, expd);
  endtask

  task automatic cyc(bit r, int f0, int f1);
    logic [159:0] w;
    @(negedge clk);
    w = mkword(f0, f1);
    rdy = r; din = w;
    @(posedge clk); #1;
    model_edge(w, r);
  endtask

  task automatic idle(int n);
    for (int i = 0; i < n; i++) cyc(1'b1, 0, 0);
  endtask

  task automatic do_reset(bit mode);
    @(negedge clk);
    rst_n = 1'b0; rdy = 1'b0; din = '0; dbl = mode;
    repeat (2) @(posedge clk);
    #1;
    model_reset();
    chk("R11", {158'd0, aligned, err}, '0);
    chk("R11", dout, '0);
    @(negedge clk);
    rst_n = 1'b1;
  endtask

  initial begin
    #(4 * 200000);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    model_reset();
    // single width, no skew
    do_reset(1'b0); tag = "R1 R4 R7 R8";
    idle(3); cyc(1, 1, 1); idle(5);
    // single width, lane 0 leads by 1
    do_reset(1'b0); tag = "R4 R5 R7";
    idle(2); cyc(1, 1, 0); cyc(1, 0, 1); idle(5);
    // single width, lane 1 leads by 2 (limit)
    do_reset(1'b0); tag = "R5 R7 R8";
    idle(1); cyc(1, 0, 1); idle(1); cyc(1, 1, 0); idle(6);
    // single width, skew 3 -> error, sticky
    do_reset(1'b0); tag = "R6";
    cyc(1, 1, 0); idle(2); cyc(1, 0, 1); cyc(1, 1, 1); idle(4);
    // single width: bit 73 is data only
    do_reset(1'b0); tag = "R2";
    cyc(1, 2, 2); cyc(1, 2, 0); idle(4); cyc(1, 1, 1); idle(3);
    // double width, four same-cycle combinations and both-bits case
    do_reset(1'b1); tag = "R3 R4"; idle(1); cyc(1, 1, 1); idle(4);
    do_reset(1'b1); tag = "R3 R4"; idle(1); cyc(1, 1, 2); idle(4);
    do_reset(1'b1); tag = "R3 R4"; idle(1); cyc(1, 2, 1); idle(4);
    do_reset(1'b1); tag = "R3 R4"; idle(1); cyc(1, 2, 2); idle(4);
    do_reset(1'b1); tag = "R3";    idle(1); cyc(1, 3, 2); idle(4);
    // double width, cross-cycle skews
    do_reset(1'b1); tag = "R3 R5 R7"; cyc(1, 0, 2); cyc(1, 1, 0); idle(4);
    do_reset(1'b1); tag = "R5 R7";    cyc(1, 1, 0); cyc(1, 0, 1); idle(4);
    do_reset(1'b1); tag = "R5 R6";    cyc(1, 1, 0); cyc(1, 0, 2); idle(4);
    do_reset(1'b1); tag = "R6";       cyc(1, 2, 0); idle(1); cyc(1, 0, 1); idle(3);
    do_reset(1'b1); tag = "R5 R8";    cyc(1, 0, 2); cyc(1, 2, 0); idle(4);
    // receiver-ready gating and restart
    do_reset(1'b0); tag = "R9";
    cyc(0, 1, 1); cyc(0, 1, 1); cyc(0, 1, 0);
    cyc(1, 1, 0); cyc(0, 0, 1); cyc(1, 0, 0);
    cyc(1, 1, 1); idle(4);
    cyc(0, 0, 0); cyc(0, 0, 0); cyc(0, 0, 0);
    cyc(1, 0, 1); cyc(1, 1, 0); idle(4);
    done = 1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule